// File: doc/BRIEF.md
# RAM Read Parity Error Interrupt Unit

This block watches read beats leaving a RAM array and checks each byte of the data word against its stored parity bit. When exactly one byte fails, it records a single-bit error. When two or more bytes fail, it records a multi-bit error. A separate strobe reports locked requests that the memory cannot serve. Each of the three sources has a sticky status bit and an enable bit. The block drives one registered interrupt line to the processor.

Software reaches the block through a small register port. A control register holds the check-disable flag and the three enables. The status register is cleared by writing ones to it. A read-only register holds the address of the first parity error; it stays frozen until both parity status bits are clear. The read stream is valid/ready. The block only observes the stream and never stalls it, so `rd_ready` is held high and every cycle with `rd_valid` high is one checked beat. The block does not generate parity and does not hold the RAM.

Top module: `ram_par_irq_unit`

## Requirements
- R1: Parity is even, one bit per byte. Bit i of `rd_par` must equal the XOR of bits 8i+7..8i of `rd_data`. A valid beat with exactly one mismatching byte sets status bit 0 (single) one clock edge later.
- R2: A valid beat with two or more mismatching bytes sets status bit 1 (multi) and not bit 0. A beat with no mismatch sets neither bit.
- R3: While control bit 0 (check disable) is 1, beats set neither parity status bit and do not change the error-address register.
- R4: A cycle with `lock_req` high sets status bit 2 (lock). This happens whether or not checking is disabled.
- R5: A write to register 1 (status) clears every status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R6: If a status bit is set by an event and cleared by software in the same cycle, the bit ends up set.
- R7: Register 2 captures `rd_addr` of a parity error only when both parity status bits will be clear after the current cycle's clear. Otherwise it holds its value. A clear in the same cycle as a new error therefore lets that error's address be captured.
- R8: `irq_o` is the OR over the status bits ANDed with control bits 1, 2 and 3 (the enables for status bits 0, 1 and 2), registered once. It follows a change in status or enables by one clock edge.
- R9: `rd_ready` is always 1. A cycle without `rd_valid` is never checked.
- R10: After reset, control, status, error address and `irq_o` are all 0. Register 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read beat present |
| rd_ready | output | 1 | Always 1; the checker never back-pressures |
| rd_data | input | DATA_W | Read data word |
| rd_par | input | DATA_W/8 | Stored parity, one bit per byte |
| rd_addr | input | ADDR_W | Address offset of the beat |
| lock_req | input | 1 | Unsupported locked request strobe |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can land in the same cycle: an error event setting a status bit, and a software write clearing that same bit. The bench provokes this by holding an erroneous read beat and a status write on the same clock edge. It then checks two things: the bit remains set, and the error address moves to the new beat because the clear re-armed the capture. A second overlap comes from a lock strobe arriving while checking is disabled. That beat must still record the lock but leave the parity bits and the address alone.

// File: rtl/ram_par_pkg.sv
package ram_par_pkg;
  localparam int CFG_AW     = 2;
  localparam int CFG_DW     = 32;
  localparam int N_SRC      = 3;

  localparam logic [CFG_AW-1:0] REG_CTRL  = 2'd0;
  localparam logic [CFG_AW-1:0] REG_STAT  = 2'd1;
  localparam logic [CFG_AW-1:0] REG_EADDR = 2'd2;

  localparam int SRC_SINGLE = 0;
  localparam int SRC_MULTI  = 1;
  localparam int SRC_LOCK   = 2;

  typedef struct packed {
    logic [N_SRC-1:0] en;
    logic             chk_off;
  } ctrl_t;
endpackage

// File: rtl/ram_par_check.sv
module ram_par_check #(
  parameter int DATA_W = 32
) (
  input  logic                valid_i,
  input  logic                chk_off_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [DATA_W/8-1:0] par_i,
  output logic                err_single_o,
  output logic                err_multi_o
);
  localparam int NB    = DATA_W / 8;
  localparam int CNT_W = $clog2(NB + 1);

  logic [NB-1:0]    bad;
  logic [CNT_W-1:0] n_bad;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bad[b] = (^data_i[8*b +: 8]) ^ par_i[b];
  end

  always_comb begin
    n_bad = '0;
    for (int i = 0; i < NB; i++) n_bad = n_bad + CNT_W'(bad[i]);
  end

  logic active;
  assign active       = valid_i & ~chk_off_i;
  assign err_single_o = active & (n_bad == CNT_W'(1));
  assign err_multi_o  = active & (n_bad >  CNT_W'(1));

  always_comb begin
    assert_excl_R2: assert (!(err_single_o && err_multi_o));
  end
endmodule

// File: rtl/ram_par_status.sv
module ram_par_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status_o[k] <= 1'b0;
      else if (set_i[k])  status_o[k] <= 1'b1;
      else if (clr_i[k])  status_o[k] <= 1'b0;
    end

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[k] && !set_i[k] |=> !status_o[k]);
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[k] && !clr_i[k] |=> status_o[k]);
    assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] && clr_i[k] |=> status_o[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(status_o & en_i);
  end

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_i == '0 |=> !irq_o);
endmodule

// File: rtl/ram_par_erraddr.sv
module ram_par_erraddr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_i,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              addr_o <= '0;
    else if (err_i && arm_i) addr_o <= addr_i;
  end

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> $stable(addr_o));
  assert_noerr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !err_i |=> $stable(addr_o));
endmodule

// File: rtl/ram_par_irq_unit.sv
module ram_par_irq_unit
  import ram_par_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_valid,
  output logic                rd_ready,
  input  logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W/8-1:0] rd_par,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                lock_req,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                irq_o
);
  ctrl_t            ctrl_q;
  logic             e_single, e_multi;
  logic [N_SRC-1:0] set_v, clr_v, status;
  logic [ADDR_W-1:0] eaddr;
  logic             arm;

  assign rd_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ctrl_q <= '0;
    else if (cfg_we && cfg_addr == REG_CTRL) ctrl_q <= cfg_wdata[N_SRC:0];
  end

  ram_par_check #(.DATA_W(DATA_W)) chk_i (
    .valid_i      (rd_valid),
    .chk_off_i    (ctrl_q.chk_off),
    .data_i       (rd_data),
    .par_i        (rd_par),
    .err_single_o (e_single),
    .err_multi_o  (e_multi)
  );

  always_comb begin
    set_v             = '0;
    set_v[SRC_SINGLE] = e_single;
    set_v[SRC_MULTI]  = e_multi;
    set_v[SRC_LOCK]   = lock_req;
    clr_v = (cfg_we && cfg_addr == REG_STAT) ? cfg_wdata[N_SRC-1:0] : '0;
  end

  ram_par_status #(.N(N_SRC)) st_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_v),
    .clr_i    (clr_v),
    .en_i     (ctrl_q.en),
    .status_o (status),
    .irq_o    (irq_o)
  );

  assign arm = ((status[SRC_MULTI:SRC_SINGLE] & ~clr_v[SRC_MULTI:SRC_SINGLE]) == 2'b00);

  ram_par_erraddr #(.ADDR_W(ADDR_W)) ea_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_i  (e_single | e_multi),
    .arm_i  (arm),
    .addr_i (rd_addr),
    .addr_o (eaddr)
  );

  always_comb begin
    case (cfg_addr)
      REG_CTRL:  cfg_rdata = 32'(ctrl_q);
      REG_STAT:  cfg_rdata = 32'(status);
      REG_EADDR: cfg_rdata = 32'(eaddr);
      default:   cfg_rdata = '0;
    endcase
  end

  assert_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.chk_off && !status[SRC_SINGLE] |=> !status[SRC_SINGLE]);
  assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> status[SRC_LOCK]);
  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready);
endmodule

// File: tb/ram_par_irq_unit_tb_top.sv
module ram_par_irq_unit_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [DW-1:0] rd_data = '0;
  logic [1:0]    rd_par = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          lock_req = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ram_par_irq_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_par(rd_par), .rd_addr(rd_addr), .lock_req(lock_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_reg(input logic [1:0] a);
    return 32'h0;
  endfunction

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    cfg_addr = a;
    #1;
    v = cfg_rdata;
  endtask

  // one cycle: optional beat, optional register write, optional lock
  task automatic cycle(input logic bv, input logic [DW-1:0] d, input logic [1:0] p,
                       input logic [AW-1:0] a, input logic we, input logic [1:0] wa,
                       input logic [31:0] wd, input logic lk);
    @(negedge clk);
    rd_valid = bv; rd_data = d; rd_par = p; rd_addr = a;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd; lock_req = lk;
    @(negedge clk);
    rd_valid = 1'b0; cfg_we = 1'b0; lock_req = 1'b0;
  endtask

  function automatic logic [1:0] good_par(input logic [DW-1:0] d);
    return {^d[15:8], ^d[7:0]};
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    peek(2'd0, v); check("R10 ctrl", v, 0);
    peek(2'd1, v); check("R10 status", v, 0);
    peek(2'd2, v); check("R10 eaddr", v, 0);
    peek(2'd3, v); check("R10 reg3", v, 0);
    check("R10 irq", {31'b0, irq_o}, 0);
    check("R9 ready", {31'b0, rd_ready}, 1);

    // R1 R2 R7 sweep
    for (int i = 0; i < 256; i++) begin
      for (int f = 0; f < 4; f++) begin
        logic [DW-1:0] d;
        logic [AW-1:0] a;
        logic [31:0] es;
        d = DW'(i * 257 + i * 3);
        a = AW'(i ^ (f << 6));
        cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h7, 1'b0);
        cycle(1'b1, d, good_par(d) ^ 2'(f), a, 1'b0, 2'd0, 0, 1'b0);
        es = (f == 0) ? 0 : (f == 3) ? 32'h2 : 32'h1;
        peek(2'd1, v); check(f == 3 ? "R2 multi" : "R1 single", v, es);
        if (f != 0) begin peek(2'd2, v); check("R7 capture", v, 32'(a)); end
      end
    end

    // R9: no valid -> no check
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h7, 1'b0);
    cycle(1'b0, 16'h0001, 2'b00, 8'h11, 1'b0, 2'd0, 0, 1'b0);
    peek(2'd1, v); check("R9 idle", v, 0);

    // R7 freeze: first error 0x21, then 0x22 multi, address stays
    cycle(1'b1, 16'h0001, 2'b00, 8'h21, 1'b0, 2'd0, 0, 1'b0);
    cycle(1'b1, 16'h0101, 2'b00, 8'h22, 1'b0, 2'd0, 0, 1'b0);
    peek(2'd1, v); check("R7 both set", v, 3);
    peek(2'd2, v); check("R7 frozen", v, 32'h21);
    // R5 clear single only, multi stays; still frozen
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h1, 1'b0);
    peek(2'd1, v); check("R5 partial clear", v, 2);
    cycle(1'b1, 16'h0001, 2'b00, 8'h23, 1'b0, 2'd0, 0, 1'b0);
    peek(2'd2, v); check("R7 still frozen", v, 32'h21);
    // R5 write zero no effect
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h0, 1'b0);
    peek(2'd1, v); check("R5 write zero", v, 3);
    // R6 collision: clear all while new single error at 0x24
    cycle(1'b1, 16'h0001, 2'b00, 8'h24, 1'b1, 2'd1, 32'h7, 1'b0);
    peek(2'd1, v); check("R6 collide", v, 1);
    peek(2'd2, v); check("R7 rearm same cycle", v, 32'h24);

    // R3 disable, R4 lock while disabled
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h7, 1'b0);
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd0, 32'h1, 1'b0);
    cycle(1'b1, 16'h0101, 2'b00, 8'h55, 1'b0, 2'd0, 0, 1'b1);
    peek(2'd1, v); check("R3 R4 disabled", v, 4);
    peek(2'd2, v); check("R3 eaddr kept", v, 32'h24);
    cycle(1'b1, 16'h0001, 2'b00, 8'h56, 1'b0, 2'd0, 0, 1'b0);
    peek(2'd1, v); check("R3 single suppressed", v, 4);

    // R8 irq timing
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h7, 1'b0);
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd0, 32'h2, 1'b0);   // enable single, checking on
    peek(2'd0, v); check("R8 ctrl readback", v, 2);
    check("R8 irq idle", {31'b0, irq_o}, 0);
    cycle(1'b1, 16'h0001, 2'b00, 8'h60, 1'b0, 2'd0, 0, 1'b1);
    check("R8 irq not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R8 irq asserted", {31'b0, irq_o}, 1);
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd0, 32'h0, 1'b0);   // drop enables
    check("R8 irq lag", {31'b0, irq_o}, 1);
    @(negedge clk);
    check("R8 irq off", {31'b0, irq_o}, 0);
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd0, 32'h8, 1'b0);   // lock enable, lock set
    @(negedge clk);
    check("R8 lock irq", {31'b0, irq_o}, 1);
    cycle(1'b0, '0, '0, '0, 1'b1, 2'd1, 32'h4, 1'b0);
    @(negedge clk);
    check("R8 irq after clear", {31'b0, irq_o}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule